// File: doc/BRIEF.md
# Bidirectional Clocked FIFO Pair

This block lets two buses running on unrelated free-running clocks exchange 18-bit words in both directions. It contains two independent first-in first-out queues, one per direction. Each side has a single data path. The side's chip select and direction select decide whether an enabled rising edge stores a word for the far side or takes a word that the far side sent.

Each queue holds 512 words by default. The fill state of each direction is carried across clock domains as a Gray-coded pointer through two flip-flop stages. Every side therefore sees an input-ready flag and an output-ready flag that are synchronous to its own clock. The bidirectional bus is modelled as a separate input vector, output vector and output-enable, with no tristate driver. When the direction select is in read mode, the output vector holds the word taken by the most recent accepted read.

Top module: `bidir_fifo_pair`

## Requirements
- R1: On a rising edge of a side's clock with select high, direction select 1 (write mode) and write enable high while input-ready is high, the side's input word is appended to the queue heading to the opposite side.
- R2: On a rising edge with select high, direction select 0 (read mode) and read enable high while output-ready is high, the oldest word of the queue arriving at that side is removed and appears on that side's output vector right after that edge. The output-enable is high whenever select is high and direction select is 0.
- R3: While select is low, both enables of that side have no effect on either queue or on the output vector, and the output-enable is low.
- R4: Each direction delivers words in the order they were written, and traffic in one direction has no effect on the other.
- R5: Input-ready goes low once a direction holds its depth in words (512 by default). Writes attempted while it is low store nothing.
- R6: Output-ready is low while a direction is empty. Reads attempted while it is low move no pointer and leave the output vector unchanged.
- R7: Status crosses domains through two register stages. Output-ready rises within 4 reading-side edges after a write into an empty direction, and input-ready rises within 4 writing-side edges after a read from a full direction.
- R8: In write mode the read enable is ignored, and in read mode the write enable is ignored.
- R9: After reset both directions are empty: input-ready is high, output-ready is low, and both output vectors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A free-running clock |
| clk_b | input | 1 | Side B free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| a_sel | input | 1 | Side A chip select, active high |
| a_wr_mode | input | 1 | Side A direction select: 1 write, 0 read |
| a_wr_en | input | 1 | Side A write enable |
| a_rd_en | input | 1 | Side A read enable |
| a_din | input | 18 | Side A word toward side B |
| a_dout | output | 18 | Side A word received from side B |
| a_oe | output | 1 | Side A output-enable for a_dout |
| a_in_rdy | output | 1 | A-to-B queue can accept a word (clk_a domain) |
| a_out_rdy | output | 1 | B-to-A queue has a word (clk_a domain) |
| b_sel | input | 1 | Side B chip select, active high |
| b_wr_mode | input | 1 | Side B direction select: 1 write, 0 read |
| b_wr_en | input | 1 | Side B write enable |
| b_rd_en | input | 1 | Side B read enable |
| b_din | input | 18 | Side B word toward side A |
| b_dout | output | 18 | Side B word received from side A |
| b_oe | output | 1 | Side B output-enable for b_dout |
| b_in_rdy | output | 1 | B-to-A queue can accept a word (clk_b domain) |
| b_out_rdy | output | 1 | A-to-B queue has a word (clk_b domain) |

## Verification
A popped word is due on the output vector at the clock edge that accepts the read. The bench decides at the preceding falling edge plus 1 ns whether that edge will accept, and compares 1 ns after the rising edge against the head of a scoreboard queue. Input-ready falls in the same edge that stores the last free slot, and is checked one half-period later. Flag changes that cross domains have a window of up to four edges of the observing clock, so the bench counts that clock's falling edges until the flag moves and requires a count of at most 4. Stimulus that must be ignored is followed by at least eight edges of the far clock before the flags and output vectors are examined.

// File: rtl/bfp_pkg.sv
`timescale 1ns/1ps
package bfp_pkg;
  localparam int unsigned WORD_W     = 18;
  localparam int unsigned FIFO_DEPTH = 512;

  typedef enum logic {
    MODE_READ  = 1'b0,
    MODE_WRITE = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/bfp_rst_sync.sv
`timescale 1ns/1ps
module bfp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stg1_q;
  logic stg2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= 1'b1;
      stg2_q <= stg1_q;
    end
  end

  assign srst_n = stg2_q;
endmodule

// File: rtl/bfp_sync.sv
`timescale 1ns/1ps
module bfp_sync #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] safe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      safe_q <= '0;
    end else begin
      meta_q <= d;
      safe_q <= meta_q;
    end
  end

  assign q = safe_q;
endmodule

// File: rtl/bfp_port_ctrl.sv
`timescale 1ns/1ps
module bfp_port_ctrl
  import bfp_pkg::*;
(
  input  logic sel,
  input  logic wr_mode,
  input  logic wr_en,
  input  logic rd_en,
  output logic push_req,
  output logic pop_req,
  output logic oe
);
  logic is_wr;
  logic is_rd;

  always_comb begin
    is_wr    = sel && (wr_mode == MODE_WRITE);
    is_rd    = sel && (wr_mode == MODE_READ);
    push_req = is_wr && wr_en;
    pop_req  = is_rd && rd_en;
    oe       = is_rd;
  end
endmodule

// File: rtl/bfp_async_fifo.sv
`timescale 1ns/1ps
module bfp_async_fifo #(
  parameter int unsigned DW    = 18,
  parameter int unsigned DEPTH = 512
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          push_req,
  input  logic [DW-1:0] wdata,
  output logic          in_rdy,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          pop_req,
  output logic [DW-1:0] rdata,
  output logic          out_rdy
);
  localparam int unsigned AW      = $clog2(DEPTH);
  localparam logic [AW:0] ONE     = (AW+1)'(1);
  localparam logic [AW:0] LVL_MAX = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [AW:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [AW:0] rgray_w, rbin_w, w_level;
  logic        full, push;

  // read domain
  logic [AW:0]   rbin_q, rbin_d, rgray_q, rgray_d;
  logic [AW:0]   wgray_r, wbin_r;
  logic [DW-1:0] rdata_q;
  logic          empty, pop;

  bfp_sync #(.W(AW+1)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_w));
  bfp_sync #(.W(AW+1)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_r));

  always_comb begin
    full    = (wgray_q == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
    push    = push_req && !full;
    wbin_d  = wbin_q + ONE;
    wgray_d = wbin_d ^ (wbin_d >> 1);
    for (int i = 0; i <= AW; i++) rbin_w[i] = ^(rgray_w >> i);
    w_level = wbin_q - rbin_w;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (push) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (push) mem[wbin_q[AW-1:0]] <= wdata;
  end

  always_comb begin
    empty   = (rgray_q == wgray_r);
    pop     = pop_req && !empty;
    rbin_d  = rbin_q + ONE;
    rgray_d = rbin_d ^ (rbin_d >> 1);
    for (int i = 0; i <= AW; i++) wbin_r[i] = ^(wgray_r >> i);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      rdata_q <= '0;
    end else if (pop) begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      rdata_q <= mem[rbin_q[AW-1:0]];
    end
  end

  assign in_rdy  = !full;
  assign out_rdy = !empty;
  assign rdata   = rdata_q;

  // R5
  wr_level_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    w_level <= LVL_MAX);

  // R6
  rd_level_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (wbin_r - rbin_q) <= LVL_MAX);

  // R6
  rdata_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!pop_req || !out_rdy) |=> $stable(rdata));

  // R7
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    $onehot0(wgray_q ^ $past(wgray_q)));

  // R1
  wptr_hold_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    !push_req |=> $stable(wbin_q));
endmodule

// File: rtl/bidir_fifo_pair.sv
`timescale 1ns/1ps
module bidir_fifo_pair
  import bfp_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned DEPTH  = FIFO_DEPTH
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              a_sel,
  input  logic              a_wr_mode,
  input  logic              a_wr_en,
  input  logic              a_rd_en,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  output logic              a_oe,
  output logic              a_in_rdy,
  output logic              a_out_rdy,
  input  logic              b_sel,
  input  logic              b_wr_mode,
  input  logic              b_wr_en,
  input  logic              b_rd_en,
  input  logic [DATA_W-1:0] b_din,
  output logic [DATA_W-1:0] b_dout,
  output logic              b_oe,
  output logic              b_in_rdy,
  output logic              b_out_rdy
);
  logic srst_a_n, srst_b_n;
  logic a_push, a_pop, b_push, b_pop;

  bfp_rst_sync u_rst_a (.clk(clk_a), .arst_n(rst_n), .srst_n(srst_a_n));
  bfp_rst_sync u_rst_b (.clk(clk_b), .arst_n(rst_n), .srst_n(srst_b_n));

  bfp_port_ctrl u_ctl_a (
    .sel(a_sel), .wr_mode(a_wr_mode), .wr_en(a_wr_en), .rd_en(a_rd_en),
    .push_req(a_push), .pop_req(a_pop), .oe(a_oe)
  );

  bfp_port_ctrl u_ctl_b (
    .sel(b_sel), .wr_mode(b_wr_mode), .wr_en(b_wr_en), .rd_en(b_rd_en),
    .push_req(b_push), .pop_req(b_pop), .oe(b_oe)
  );

  bfp_async_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_a2b (
    .wclk(clk_a), .wrst_n(srst_a_n), .push_req(a_push), .wdata(a_din), .in_rdy(a_in_rdy),
    .rclk(clk_b), .rrst_n(srst_b_n), .pop_req(b_pop), .rdata(b_dout), .out_rdy(b_out_rdy)
  );

  bfp_async_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_b2a (
    .wclk(clk_b), .wrst_n(srst_b_n), .push_req(b_push), .wdata(b_din), .in_rdy(b_in_rdy),
    .rclk(clk_a), .rrst_n(srst_a_n), .pop_req(a_pop), .rdata(a_dout), .out_rdy(a_out_rdy)
  );
endmodule

// File: tb/sim_bidir_fifo_pair.sv
`timescale 1ns/1ps
module sim_bidir_fifo_pair;
  localparam int DW    = 18;
  localparam int DEPTH = 512;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_n;
  always #2   clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  logic          a_sel, a_wr_mode, a_wr_en, a_rd_en;
  logic [DW-1:0] a_din, a_dout;
  logic          a_oe, a_in_rdy, a_out_rdy;
  logic          b_sel, b_wr_mode, b_wr_en, b_rd_en;
  logic [DW-1:0] b_din, b_dout;
  logic          b_oe, b_in_rdy, b_out_rdy;

  bidir_fifo_pair u0 (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_sel(a_sel), .a_wr_mode(a_wr_mode), .a_wr_en(a_wr_en), .a_rd_en(a_rd_en),
    .a_din(a_din), .a_dout(a_dout), .a_oe(a_oe), .a_in_rdy(a_in_rdy), .a_out_rdy(a_out_rdy),
    .b_sel(b_sel), .b_wr_mode(b_wr_mode), .b_wr_en(b_wr_en), .b_rd_en(b_rd_en),
    .b_din(b_din), .b_dout(b_dout), .b_oe(b_oe), .b_in_rdy(b_in_rdy), .b_out_rdy(b_out_rdy)
  );

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] q_ab[$];
  logic [DW-1:0] q_ba[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1 driver: queue a word only when the edge will accept it
  task automatic a_write(input int n, input int base, output int acc);
    acc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_a);
      a_sel = 1; a_wr_mode = 1; a_wr_en = 1; a_rd_en = 0; a_din = DW'(base + i);
      #1;
      if (a_in_rdy) begin q_ab.push_back(a_din); acc++; end
    end
    @(negedge clk_a);
    a_wr_en = 0; a_sel = 0;
  endtask

  task automatic b_write(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_b);
      b_sel = 1; b_wr_mode = 1; b_wr_en = 1; b_rd_en = 0; b_din = DW'(base + i);
      #1;
      if (b_in_rdy) q_ba.push_back(b_din);
    end
    @(negedge clk_b);
    b_wr_en = 0; b_sel = 0;
  endtask

  task automatic b_read(input int n);
    int got = 0;
    int tries = 0;
    while (got < n && tries < 4000) begin
      @(negedge clk_b);
      b_sel = 1; b_wr_mode = 0; b_rd_en = 1;
      #1;
      if (b_out_rdy) got++;
      tries++;
    end
    @(negedge clk_b);
    b_rd_en = 0; b_sel = 0;
    chk(got == n, "R2 B read count", got, n);
  endtask

  task automatic a_read(input int n);
    int got = 0;
    int tries = 0;
    while (got < n && tries < 4000) begin
      @(negedge clk_a);
      a_sel = 1; a_wr_mode = 0; a_rd_en = 1;
      #1;
      if (a_out_rdy) got++;
      tries++;
    end
    @(negedge clk_a);
    a_rd_en = 0; a_sel = 0;
    chk(got == n, "R2 A read count", got, n);
  endtask

  // monitors: decide before the edge, compare right after it
  initial begin
    bit will;
    logic [DW-1:0] exp;
    forever begin
      @(negedge clk_b); #1;
      will = b_sel && !b_wr_mode && b_rd_en && b_out_rdy;
      @(posedge clk_b); #1;
      if (will) begin
        if (q_ab.size() == 0) chk(0, "R4 B pop with empty scoreboard", b_dout, 0);
        else begin
          exp = q_ab.pop_front();
          chk(b_dout == exp, "R1 R2 R4 A-to-B word", b_dout, exp);
        end
      end
    end
  end

  initial begin
    bit will;
    logic [DW-1:0] exp;
    forever begin
      @(negedge clk_a); #1;
      will = a_sel && !a_wr_mode && a_rd_en && a_out_rdy;
      @(posedge clk_a); #1;
      if (will) begin
        if (q_ba.size() == 0) chk(0, "R4 A pop with empty scoreboard", a_dout, 0);
        else begin
          exp = q_ba.pop_front();
          chk(a_dout == exp, "R2 R4 B-to-A word", a_dout, exp);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_a);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int acc;
    a_sel = 0; a_wr_mode = 0; a_wr_en = 0; a_rd_en = 0; a_din = '0;
    b_sel = 0; b_wr_mode = 0; b_wr_en = 0; b_rd_en = 0; b_din = '0;
    rst_n = 0;
    repeat (5) @(negedge clk_b);
    rst_n = 1;
    repeat (4) @(negedge clk_b);

    // R9
    chk(a_in_rdy == 1, "R9 a_in_rdy", a_in_rdy, 1);
    chk(b_in_rdy == 1, "R9 b_in_rdy", b_in_rdy, 1);
    chk(a_out_rdy == 0, "R9 a_out_rdy", a_out_rdy, 0);
    chk(b_out_rdy == 0, "R9 b_out_rdy", b_out_rdy, 0);
    chk(a_dout == 0, "R9 a_dout", a_dout, 0);
    chk(b_dout == 0, "R9 b_dout", b_dout, 0);

    // R3: deselected write attempts
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_a);
      a_sel = 0; a_wr_mode = 1; a_wr_en = 1; a_din = DW'(5);
    end
    @(negedge clk_a); a_wr_en = 0; a_wr_mode = 0;
    #1 chk(a_oe == 0, "R3 a_oe with select low", a_oe, 0);
    repeat (8) @(negedge clk_b);
    chk(b_out_rdy == 0, "R3 no store while deselected", b_out_rdy, 0);

    // R8: write enable in read mode
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_a);
      a_sel = 1; a_wr_mode = 0; a_wr_en = 1; a_din = DW'(7);
    end
    #1 chk(a_oe == 1, "R2 a_oe in read mode", a_oe, 1);
    @(negedge clk_a); a_wr_en = 0; a_sel = 0;
    repeat (8) @(negedge clk_b);
    chk(b_out_rdy == 0, "R8 wr_en ignored in read mode", b_out_rdy, 0);

    // R7: output-ready latency after first word
    a_write(1, 100, acc);
    n = 0;
    while (!b_out_rdy && n < 8) begin @(negedge clk_b); n++; end
    chk(b_out_rdy && n <= 4, "R7 b_out_rdy latency", n, 4);

    a_write(9, 101, acc);
    b_write(6, 500);
    repeat (8) @(negedge clk_b);

    // R8: read enable in write mode
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_b);
      b_sel = 1; b_wr_mode = 1; b_wr_en = 0; b_rd_en = 1;
    end
    @(negedge clk_b); b_rd_en = 0; b_sel = 0;
    chk(b_dout == 0, "R8 rd_en ignored in write mode", b_dout, 0);
    chk(b_oe == 0, "R3 b_oe low after deselect", b_oe, 0);

    // R3: deselected read attempts
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_b);
      b_sel = 0; b_wr_mode = 0; b_rd_en = 1;
    end
    @(negedge clk_b); b_rd_en = 0;
    chk(b_dout == 0, "R3 rd_en ignored while deselected", b_dout, 0);
    chk(b_out_rdy == 1, "R3 data still waiting", b_out_rdy, 1);

    // R4: both directions drained independently
    a_read(6);
    b_read(10);
    chk(q_ab.size() == 0, "R4 A-to-B drained", q_ab.size(), 0);
    chk(q_ba.size() == 0, "R4 B-to-A drained", q_ba.size(), 0);

    // R6: reads on empty
    repeat (4) @(negedge clk_b);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_b);
      b_sel = 1; b_wr_mode = 0; b_rd_en = 1;
    end
    @(negedge clk_b); b_rd_en = 0; b_sel = 0;
    chk(b_dout == 109, "R6 dout held on empty read", b_dout, 109);
    chk(b_out_rdy == 0, "R6 out_rdy low when empty", b_out_rdy, 0);
    a_write(1, 200, acc);
    b_read(1);

    // R5: fill to depth plus two
    a_write(DEPTH + 2, 1000, acc);
    chk(acc == DEPTH, "R5 accepted words", acc, DEPTH);
    chk(a_in_rdy == 0, "R5 in_rdy low when full", a_in_rdy, 0);
    repeat (6) @(negedge clk_a);
    chk(a_in_rdy == 0, "R5 in_rdy stays low", a_in_rdy, 0);

    // R7: input-ready latency after one read
    b_read(1);
    n = 0;
    while (!a_in_rdy && n < 8) begin @(negedge clk_a); n++; end
    chk(a_in_rdy && n <= 4, "R7 a_in_rdy latency", n, 4);

    b_read(DEPTH - 1);
    repeat (4) @(negedge clk_b);
    chk(q_ab.size() == 0, "R5 extra writes not stored", q_ab.size(), 0);
    chk(b_out_rdy == 0, "R6 empty after drain", b_out_rdy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule